// File: doc/BRIEF.md
# Clock-Controlled Multi-Register Keystream Generator

This block produces one keystream bit per enabled step for a binary additive stream cipher. A regularly stepped control register runs through a de Bruijn sequence. The register is built as a maximal-length shift register with extra logic that inserts the all-zero state once per period. On every step, a small selection code is read from key-chosen stages of the control register. That code names the one generating register, out of four primitive LFSRs, that advances on that step. All other generating registers hold their state. The keystream bit is the XOR of the output stages of all generating registers, taken after the selected register has moved.

A key load sets several things in one cycle: the control register contents, the contents of every generating register, and the positions of the control stages that form the selection code. The load has priority over stepping. A key that leaves any generating register at all-zero is refused. The block then raises an error flag and never asserts keystream-valid until a good key arrives. An optional output XORs the current keystream bit with a plaintext bit.

Top module: `cc_keystream`

## Requirements
- R1: After reset, ks_valid, ks_bit and key_err are 0, and ks_valid stays 0 whatever step_en does until a valid key has been loaded.
- R2: Each step shifts the 64-bit control register c left: the new c[0] is c[63]^c[62]^c[60]^c[59], inverted when c[62:0] is all zero. The control state therefore goes from 0x8000000000000000 to 0 and then to 1.
- R3: Each step advances exactly one generating register. Its index is {c[s1], c[s0]}, read from the control state as it was before the step. s0 is key_stage[5:0] and gives bit 0 of the index; s1 is key_stage[11:6].
- R4: Generating register i (31 bits, g) advances by shifting left with new g[0] = g[30]^g[30-k], where k is 3, 6, 7 and 13 for i = 0, 1, 2, 3. Its output stage is g[30].
- R5: When step_en is high at a clock edge with a valid key and no load, ks_valid is 1 after that edge and ks_bit is the XOR of the four output stages after the advance. After any edge without a step, ks_valid is 0.
- R6: When key_load is high, register i takes key_gen[31i+30:31i], the control register takes key_ctrl, and the stage indices take key_stage. No step happens at that edge, even with step_en high, and ks_valid is 0 after it.
- R7: A load in which any 31-bit field of key_gen is zero sets key_err to 1 and blocks all steps until a load with every field nonzero, which clears key_err.
- R8: While step_en is low, no register changes. When stepping resumes, the keystream continues exactly as if the pause had not happened.
- R9: ct_bit equals ks_bit XOR pt_bit at all times.
- R10: Any pair of stage indices from 0 to 63 is accepted. Each index reads the control stage at that bit position, with 0 selecting c[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Load key material this cycle |
| key_ctrl | input | 64 | Control register initial contents |
| key_gen | input | 124 | Generating register initial contents, register i at bits 31i+30:31i |
| key_stage | input | 12 | Two 6-bit control stage indices, s0 in bits 5:0 |
| step_en | input | 1 | Request one keystream step this cycle |
| pt_bit | input | 1 | Plaintext bit for the XOR output |
| ks_valid | output | 1 | ks_bit holds the bit of a step made at the last edge |
| ks_bit | output | 1 | Keystream bit |
| ct_bit | output | 1 | ks_bit XOR pt_bit |
| key_err | output | 1 | Last key loaded had an all-zero generating register |

## Verification
A wrong control-register state changes the selection code, so the wrong generating register moves. Once the outputs of the two registers differ, a keystream mismatch appears within a few steps. Tests that start the control register next to the inserted zero state, with stages 0 and 1 selected, show a missing or misplaced zero insertion in the first steps. A wrong feedback tap in a generating register appears in the keystream only after the corrupted bit has shifted to the output stage, up to 31 advances of that register later. For that reason the comparison runs over several hundred consecutive steps. Errors in load priority, pausing or key refusal show one edge later on ks_valid or key_err.

// File: rtl/cck_pkg.sv
package cck_pkg;
  localparam int CMAX = 64;

  // Control register tap mask (bit positions fed into the XOR), by length.
  function automatic logic [CMAX-1:0] ctrl_taps(input int len);
    logic [CMAX-1:0] m;
    m = '0;
    case (len)
      64: begin m[63] = 1'b1; m[62] = 1'b1; m[60] = 1'b1; m[59] = 1'b1; end
      8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
      default: begin m[len-1] = 1'b1; m[0] = 1'b1; end
    endcase
    return m;
  endfunction

  // Middle exponent k of trinomial x^len + x^k + 1 for generating register idx.
  function automatic int gen_tap(input int len, input int idx);
    int k;
    k = 1;
    case (len)
      31: case (idx) 0: k = 3; 1: k = 6; 2: k = 7; default: k = 13; endcase
      7:  case (idx) 0: k = 1; 1: k = 3; 2: k = 4; default: k = 6; endcase
      default: k = 1;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/cck_ctrl_reg.sv
module cck_ctrl_reg #(
  parameter int CTRL_LEN = 64,
  parameter int W        = 2,
  parameter int IDXW     = $clog2(CTRL_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CTRL_LEN-1:0] seed,
  input  logic [W*IDXW-1:0]   idx_flat,
  input  logic                adv,
  output logic [CTRL_LEN-1:0] state,
  output logic [W-1:0]        sel
);
  localparam logic [cck_pkg::CMAX-1:0] TAPM = cck_pkg::ctrl_taps(CTRL_LEN);

  // Maximal-length step with the all-zero state spliced into the cycle.
  function automatic logic [CTRL_LEN-1:0] db_next(input logic [CTRL_LEN-1:0] s);
    logic fb;
    fb = ^(s & TAPM[CTRL_LEN-1:0]);
    fb = fb ^ (s[CTRL_LEN-2:0] == '0);
    return {s[CTRL_LEN-2:0], fb};
  endfunction

  logic [IDXW-1:0] idx_q [W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '0;
    end else if (load) begin
      state <= seed;
    end else if (adv) begin
      state <= db_next(state);
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)    idx_q[j] <= '0;
      else if (load) idx_q[j] <= idx_flat[j*IDXW +: IDXW];
    end
    assign sel[j] = state[idx_q[j]];
  end
endmodule

// File: rtl/cck_gen_lfsr.sv
module cck_gen_lfsr #(
  parameter int LEN = 31,
  parameter int K   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           adv,
  output logic [LEN-1:0] state,
  output logic           out_next
);
  function automatic logic [LEN-1:0] lfsr_next(input logic [LEN-1:0] s);
    return {s[LEN-2:0], s[LEN-1] ^ s[LEN-1-K]};
  endfunction

  logic [LEN-1:0] nxt;
  assign nxt      = lfsr_next(state);
  assign out_next = adv ? nxt[LEN-1] : state[LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= seed;
    else if (adv)  state <= nxt;
  end
endmodule

// File: rtl/cc_keystream.sv
module cc_keystream #(
  parameter int CTRL_LEN = 64,
  parameter int N_GEN    = 4,
  parameter int GEN_LEN  = 31,
  parameter bit PT_XOR   = 1'b1,
  localparam int W       = $clog2(N_GEN),
  localparam int IDXW    = $clog2(CTRL_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     key_load,
  input  logic [CTRL_LEN-1:0]      key_ctrl,
  input  logic [N_GEN*GEN_LEN-1:0] key_gen,
  input  logic [W*IDXW-1:0]        key_stage,
  input  logic                     step_en,
  input  logic                     pt_bit,
  output logic                     ks_valid,
  output logic                     ks_bit,
  output logic                     ct_bit,
  output logic                     key_err
);
  logic                     key_ok_q;
  logic                     step;
  logic                     bad_key;
  logic [W-1:0]             sel_code;
  logic [CTRL_LEN-1:0]      ctrl_state;
  logic [N_GEN-1:0]         gen_adv;
  logic [N_GEN-1:0]         out_next;
  logic [N_GEN-1:0]         seed_zero;
  logic [N_GEN*GEN_LEN-1:0] gen_flat;

  assign step = step_en & key_ok_q & ~key_load;

  cck_ctrl_reg #(.CTRL_LEN(CTRL_LEN), .W(W), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(key_load), .seed(key_ctrl),
    .idx_flat(key_stage), .adv(step), .state(ctrl_state), .sel(sel_code)
  );

  for (genvar i = 0; i < N_GEN; i++) begin : g_gen
    localparam int KI = cck_pkg::gen_tap(GEN_LEN, i);
    assign gen_adv[i]   = step && (sel_code == W'(i));
    assign seed_zero[i] = (key_gen[i*GEN_LEN +: GEN_LEN] == '0);
    cck_gen_lfsr #(.LEN(GEN_LEN), .K(KI)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(key_load),
      .seed(key_gen[i*GEN_LEN +: GEN_LEN]), .adv(gen_adv[i]),
      .state(gen_flat[i*GEN_LEN +: GEN_LEN]), .out_next(out_next[i])
    );
  end

  assign bad_key = |seed_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_ok_q <= 1'b0;
      key_err  <= 1'b0;
      ks_valid <= 1'b0;
      ks_bit   <= 1'b0;
    end else if (key_load) begin
      key_ok_q <= ~bad_key;
      key_err  <= bad_key;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= step;
      if (step) ks_bit <= ^out_next;
    end
  end

  if (PT_XOR) begin : g_ct
    assign ct_bit = ks_bit ^ pt_bit;
  end else begin : g_noct
    assign ct_bit = ks_bit;
  end
endmodule

// File: rtl/cc_keystream_chk.sv
module cc_keystream_chk #(
  parameter int CTRL_LEN = 64,
  parameter int N_GEN    = 4,
  parameter int GEN_LEN  = 31
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     key_load,
  input logic                     step,
  input logic                     ks_valid,
  input logic                     key_err,
  input logic [CTRL_LEN-1:0]      ctrl_state,
  input logic [N_GEN*GEN_LEN-1:0] gen_flat,
  input logic [N_GEN-1:0]         gen_adv
);
  p_single_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ($countones(gen_adv) == 1));

  p_ctrl_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ctrl_state != $past(ctrl_state)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !key_load) |=> ($stable(ctrl_state) && $stable(gen_flat)));

  p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ks_valid);

  p_novalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !ks_valid);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |-> !ks_valid);
endmodule

bind cc_keystream cc_keystream_chk #(
  .CTRL_LEN(CTRL_LEN), .N_GEN(N_GEN), .GEN_LEN(GEN_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_load(key_load), .step(step),
  .ks_valid(ks_valid), .key_err(key_err), .ctrl_state(ctrl_state),
  .gen_flat(gen_flat), .gen_adv(gen_adv)
);

// File: tb/cc_keystream_bench.sv
module cc_keystream_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [63:0]  key_ctrl = '0;
  logic [123:0] key_gen = '0;
  logic [11:0]  key_stage = '0;
  logic         step_en = 1'b0;
  logic         pt_bit = 1'b0;
  logic         ks_valid, ks_bit, ct_bit, key_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_keystream u_cc_keystream (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_ctrl(key_ctrl),
    .key_gen(key_gen), .key_stage(key_stage), .step_en(step_en),
    .pt_bit(pt_bit), .ks_valid(ks_valid), .ks_bit(ks_bit),
    .ct_bit(ct_bit), .key_err(key_err)
  );

  // Reference model state
  logic [63:0] m_c;
  logic [30:0] m_g [4];
  int          m_s0, m_s1;
  logic        m_ks;
  const int    kexp [4] = '{3, 6, 7, 13};

  function automatic logic [63:0] m_ctrl_nx(input logic [63:0] c);
    logic rest_zero;
    rest_zero = 1'b1;
    for (int b = 0; b < 63; b++) if (c[b]) rest_zero = 1'b0;
    return (c << 1) | 64'(c[63] ^ c[62] ^ c[60] ^ c[59] ^ rest_zero);
  endfunction

  function automatic logic [30:0] m_gen_nx(input logic [30:0] g, input int k);
    return (g << 1) | 31'(g[30] ^ g[30-k]);
  endfunction

  task automatic m_step();
    int idx;
    idx = 2 * int'(m_c[m_s1]) + int'(m_c[m_s0]);
    m_g[idx] = m_gen_nx(m_g[idx], kexp[idx]);
    m_c = m_ctrl_nx(m_c);
    m_ks = m_g[0][30] ^ m_g[1][30] ^ m_g[2][30] ^ m_g[3][30];
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Load a key at the current negedge; returns at the following negedge.
  task automatic load_key(input logic [63:0] c, input logic [30:0] g0, g1, g2, g3,
                          input int s0, input int s1, input logic en_too);
    key_ctrl  = c;
    key_gen   = {g3, g2, g1, g0};
    key_stage = {6'(s1), 6'(s0)};
    key_load  = 1'b1;
    step_en   = en_too;
    if (g0 != 0 && g1 != 0 && g2 != 0 && g3 != 0) begin
      m_c = c; m_g[0] = g0; m_g[1] = g1; m_g[2] = g2; m_g[3] = g3;
      m_s0 = s0; m_s1 = s1;
    end
    @(negedge clk);
    key_load = 1'b0;
    step_en  = 1'b0;
    check("R6 ks_valid low after load", 64'(ks_valid), 64'd0);
  endtask

  // Run n consecutive steps, comparing every keystream bit with the model.
  task automatic run_steps(input int n, input string req);
    step_en = 1'b1;
    for (int t = 0; t < n; t++) begin
      pt_bit = 1'(t % 3 == 0);
      @(negedge clk);
      m_step();
      if (ks_valid !== 1'b1 || ks_bit !== m_ks) begin
        check({req, " step bit"}, {62'd0, ks_valid, ks_bit}, {62'd1, 1'b1, m_ks});
      end else begin
        checks++;
      end
    end
    step_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ks_valid at reset", 64'(ks_valid), 64'd0);
    check("R1 ks_bit at reset", 64'(ks_bit), 64'd0);
    check("R1 key_err at reset", 64'(key_err), 64'd0);
    step_en = 1'b1;
    repeat (3) @(negedge clk);
    step_en = 1'b0;
    check("R1 no output without key", 64'(ks_valid), 64'd0);
  endtask

  task automatic t_stream();
    load_key(64'h0123_4567_89AB_CDEF, 31'h1, 31'h2AAA_5555, 31'h7FFF_FFFF, 31'h0BAD_F00D,
             5, 40, 1'b0);
    check("R7 key_err clear on good key", 64'(key_err), 64'd0);
    run_steps(400, "R3 R4 R5 stream");
  endtask

  task automatic t_debruijn();
    // Control starts one step before the inserted zero; stages 0 and 1 select.
    load_key(64'h8000_0000_0000_0000, 31'h1234567, 31'h7654321, 31'h0F0F0F0, 31'h3C3C3C3,
             0, 1, 1'b0);
    run_steps(300, "R2 zero insertion");
  endtask

  task automatic t_stage_idx();
    load_key(64'hFEDC_BA98_7654_3210, 31'h5A5A5A5, 31'h1, 31'h40000000, 31'h22222222,
             63, 17, 1'b0);
    run_steps(300, "R10 high stage indices");
  endtask

  task automatic t_pause();
    load_key(64'hDEAD_BEEF_CAFE_F00D, 31'h11111111, 31'h0000ABCD, 31'h3, 31'h6000_0001,
             9, 33, 1'b0);
    run_steps(20, "R8 before pause");
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check("R8 ks_valid low while paused", 64'(ks_valid), 64'd0);
    end
    run_steps(60, "R8 after pause");
  endtask

  task automatic t_load_priority();
    load_key(64'h0000_0000_0000_0003, 31'h1F, 31'hE0, 31'h700, 31'h3800, 2, 3, 1'b1);
    run_steps(50, "R6 no step at load edge");
  endtask

  task automatic t_zero_seed();
    load_key(64'h1, 31'h1, 31'h1, 31'h0, 31'h1, 0, 0, 1'b0);
    check("R7 key_err on zero seed", 64'(key_err), 64'd1);
    step_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check("R7 ks_valid blocked", 64'(ks_valid), 64'd0);
    end
    step_en = 1'b0;
    load_key(64'h77, 31'h9, 31'h8, 31'h7, 31'h6, 4, 2, 1'b0);
    check("R7 key_err cleared", 64'(key_err), 64'd0);
    run_steps(40, "R7 after recovery");
  endtask

  task automatic t_ct();
    for (int v = 0; v < 2; v++) begin
      pt_bit = 1'(v);
      #1;
      check("R9 ct_bit", 64'(ct_bit), 64'(ks_bit ^ pt_bit));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_ct();
    t_debruijn();
    t_stage_idx();
    t_pause();
    t_load_priority();
    t_zero_seed();
    t_ct();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule